// File: doc/BRIEF.md
# Key lifetime guard with timed erasure

This block keeps a secret cipher key in a bank of word registers and limits how long that key stays usable. A host loads the key words and a timeout through a small word-addressed register bus, then issues an init command. The key bus feeds an external cipher engine that expands the key. The engine reports completion by raising its ready line. From that point the key counts as loaded and a countdown begins.

The host keeps the key alive by reading the status word. Every such read reloads the countdown to the current timeout value. If the countdown runs out, or the host writes the wipe command, the key bank is cleared. The block then sends the engine a one-cycle wipe strobe together with a one-cycle init request, so the engine rebuilds its schedule from an all-zero key and not from the old secret.

The register bus has no valid/ready handshake. A host access is a single cycle with chip select high, completes at the next clock edge and is never stalled. Read data is combinational during the access cycle. The engine lines are plain control pins.

Top module: `keyguard_ctrl`

## Requirements
- R1: After reset the key bus is all zeros, the loaded flag and all three engine strobes are low, and the timeout word at address 0x0b reads the nonzero default TIMEOUT_RST.
- R2: Key words are written at addresses 0x10 to 0x17. The word at 0x10 drives key bus bits 255:224 and the word at 0x17 drives bits 31:0. Reads of these addresses return zero.
- R3: The timeout word at address 0x0b reads back exactly the last value written.
- R4: A write to the control word at 0x08 with bit 0 set makes eng_init high for exactly the cycle after the write. Bit 1 does the same for eng_next.
- R5: A read of the status word at 0x09 returns eng_ready in bit 0, eng_valid in bit 1, the loaded flag in bit 2 and zero in all other bits.
- R6: A rising edge on eng_ready while a host init is outstanding sets the loaded flag and loads the countdown with the timeout value. The countdown then drops by one per cycle. Without pings, the key is erased at the clock edge timeout+1 cycles after that completion edge.
- R7: A status read while loaded reloads the countdown, so a key that is pinged at intervals shorter than the timeout is never erased.
- R8: A control write with bit 2 set erases the key at that write's clock edge, whatever count remains.
- R9: On any erasure the key bus becomes all zeros, the loaded flag falls, and eng_zeroise and eng_init are both high for that one following cycle. The engine's completion of the re-expansion does not set the loaded flag.
- R10: While not loaded, the countdown holds at zero, a status read has no effect, and no erasure strobe is produced.
- R11: Writing the timeout word does not change a running countdown. The new value is used from the next init completion or ping.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_cs | input | 1 | Register access in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid during a read cycle |
| eng_ready | input | 1 | Engine idle / expansion complete |
| eng_valid | input | 1 | Engine result valid, reported in status |
| eng_init | output | 1 | One-cycle key expansion request |
| eng_next | output | 1 | One-cycle block processing request |
| eng_zeroise | output | 1 | One-cycle erasure notice |
| key_loaded | output | 1 | Key expanded and still alive |
| eng_key | output | 256 | Key bus to the engine |

## Verification
The bench uses the default geometry of eight 32-bit key words, so the word order on the 256-bit key bus is checked at full width. It lowers TIMEOUT_RST to 64 and writes short timeouts of 4 to 12 cycles. This brings the exact expiry edge, the reload by a ping and the change of timeout during a running count within a few dozen cycles. A behavioural engine drops ready for four cycles after every init request, so the bench also covers the re-expansion that follows an erasure.

// File: rtl/keyguard_pkg.sv
package keyguard_pkg;
  localparam int ADDR_W = 8;
  localparam logic [ADDR_W-1:0] A_CTRL   = 8'h08;
  localparam logic [ADDR_W-1:0] A_STATUS = 8'h09;
  localparam logic [ADDR_W-1:0] A_TMO    = 8'h0b;
  localparam logic [ADDR_W-1:0] A_KEY0   = 8'h10;

  localparam int C_INIT = 0;
  localparam int C_NEXT = 1;
  localparam int C_WIPE = 2;

  localparam int S_READY  = 0;
  localparam int S_VALID  = 1;
  localparam int S_LOADED = 2;

  typedef struct packed {
    logic init;
    logic next;
    logic wipe;
  } host_cmd_t;
endpackage

// File: rtl/keyguard_keybank.sv
module keyguard_keybank #(
  parameter int KEY_WORDS = 8,
  parameter int WORD_W    = 32,
  localparam int IDX_W    = $clog2(KEY_WORDS),
  localparam int KEY_W    = KEY_WORDS * WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              wipe,
  output logic [KEY_W-1:0]  key_out
);
  // Word 0 is the most significant word on the key bus.
  for (genvar i = 0; i < KEY_WORDS; i++) begin : g_word
    logic [WORD_W-1:0] word_q;
    always_ff @(posedge clk) begin
      if (!rst_n || wipe)
        word_q <= '0;
      else if (wr_en && wr_idx == IDX_W'(i))
        word_q <= wr_data;
    end
    assign key_out[(KEY_WORDS-1-i)*WORD_W +: WORD_W] = word_q;
  end

  // R9
  wipe_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wipe |=> key_out == '0);
endmodule

// File: rtl/keyguard_timer.sv
module keyguard_timer #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,
  input  logic             ping,
  input  logic             wipe_cmd,
  input  logic [CNT_W-1:0] reload_val,
  output logic             loaded,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_q;

  assign expire = loaded && (cnt_q == '0) && !ping && !arm;

  always_ff @(posedge clk) begin
    if (!rst_n || wipe_cmd || expire) begin
      loaded <= 1'b0;
      cnt_q  <= '0;
    end else if (arm) begin
      loaded <= 1'b1;
      cnt_q  <= reload_val;
    end else if (loaded && ping) begin
      cnt_q  <= reload_val;
    end else if (loaded) begin
      cnt_q  <= cnt_q - CNT_W'(1);
    end
  end

  // R6
  countdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (loaded && !ping && !arm && !wipe_cmd && cnt_q != '0) |=> cnt_q == $past(cnt_q) - CNT_W'(1));

  // R7
  ping_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (loaded && ping && !wipe_cmd) |=> (loaded && cnt_q == $past(reload_val)));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!loaded && !arm) |=> (!loaded && cnt_q == '0));
endmodule

// File: rtl/keyguard_seq.sv
module keyguard_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic host_init,
  input  logic host_next,
  input  logic wipe,
  input  logic eng_ready,
  output logic arm,
  output logic eng_init,
  output logic eng_next,
  output logic eng_zeroise
);
  logic ready_q;
  logic pending_q;

  assign arm = pending_q && eng_ready && !ready_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ready_q     <= 1'b0;
      pending_q   <= 1'b0;
      eng_init    <= 1'b0;
      eng_next    <= 1'b0;
      eng_zeroise <= 1'b0;
    end else begin
      ready_q     <= eng_ready;
      eng_init    <= host_init || wipe;
      eng_next    <= host_next;
      eng_zeroise <= wipe;
      if (wipe)
        pending_q <= 1'b0;
      else if (host_init)
        pending_q <= 1'b1;
      else if (arm)
        pending_q <= 1'b0;
    end
  end

  // R9
  wipe_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_zeroise |-> eng_init);

  // R9
  no_arm_after_wipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wipe |=> !arm);
endmodule

// File: rtl/keyguard_ctrl.sv
module keyguard_ctrl #(
  parameter int KEY_WORDS            = 8,
  parameter int WORD_W               = 32,
  parameter logic [WORD_W-1:0] TIMEOUT_RST = 32'h0000_1000,
  localparam int IDX_W               = $clog2(KEY_WORDS),
  localparam int KEY_W               = KEY_WORDS * WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_cs,
  input  logic              bus_we,
  input  logic [7:0]        bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  input  logic              eng_ready,
  input  logic              eng_valid,
  output logic              eng_init,
  output logic              eng_next,
  output logic              eng_zeroise,
  output logic              key_loaded,
  output logic [KEY_W-1:0]  eng_key
);
  import keyguard_pkg::*;

  logic              wr, rd, ping;
  logic [7:0]        key_off;
  logic              key_wr;
  logic [WORD_W-1:0] tmo_q;
  host_cmd_t         cmd;
  logic              expire, wipe, arm;

  assign wr      = bus_cs && bus_we;
  assign rd      = bus_cs && !bus_we;
  assign ping    = rd && bus_addr == A_STATUS;
  assign key_off = bus_addr - A_KEY0;
  assign key_wr  = wr && bus_addr >= A_KEY0 && key_off < 8'(KEY_WORDS);

  always_comb begin
    cmd      = '0;
    if (wr && bus_addr == A_CTRL) begin
      cmd.init = bus_wdata[C_INIT];
      cmd.next = bus_wdata[C_NEXT];
      cmd.wipe = bus_wdata[C_WIPE];
    end
  end

  assign wipe = cmd.wipe || expire;

  always_ff @(posedge clk) begin
    if (!rst_n)
      tmo_q <= TIMEOUT_RST;
    else if (wr && bus_addr == A_TMO)
      tmo_q <= bus_wdata;
  end

  always_comb begin
    bus_rdata = '0;
    if (rd) begin
      if (bus_addr == A_STATUS) begin
        bus_rdata[S_READY]  = eng_ready;
        bus_rdata[S_VALID]  = eng_valid;
        bus_rdata[S_LOADED] = key_loaded;
      end else if (bus_addr == A_TMO) begin
        bus_rdata = tmo_q;
      end
    end
  end

  keyguard_keybank #(.KEY_WORDS(KEY_WORDS), .WORD_W(WORD_W)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (key_wr),
    .wr_idx  (key_off[IDX_W-1:0]),
    .wr_data (bus_wdata),
    .wipe    (wipe),
    .key_out (eng_key)
  );

  keyguard_timer #(.CNT_W(WORD_W)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .arm        (arm),
    .ping       (ping),
    .wipe_cmd   (cmd.wipe),
    .reload_val (tmo_q),
    .loaded     (key_loaded),
    .expire     (expire)
  );

  keyguard_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_init   (cmd.init),
    .host_next   (cmd.next),
    .wipe        (wipe),
    .eng_ready   (eng_ready),
    .arm         (arm),
    .eng_init    (eng_init),
    .eng_next    (eng_next),
    .eng_zeroise (eng_zeroise)
  );

  // R9
  loaded_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(key_loaded) |-> (eng_zeroise && eng_key == '0));

  // R8
  cmd_wipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd.wipe |=> (!key_loaded && eng_zeroise));
endmodule

// File: tb/keyguard_ctrl_bench.sv
`timescale 1ns/1ps
module keyguard_ctrl_bench;
  localparam logic [7:0] A_CTRL = 8'h08, A_STATUS = 8'h09, A_TMO = 8'h0b, A_KEY0 = 8'h10;
  localparam logic [31:0] TRST = 32'h40;

  logic clk = 0, rst_n = 0;
  logic bus_cs = 0, bus_we = 0;
  logic [7:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic eng_ready = 1, eng_valid = 1;
  logic eng_init, eng_next, eng_zeroise, key_loaded;
  logic [255:0] eng_key, key_exp;

  int checks = 0, errors = 0, eng_busy = 0;
  bit done = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  always #2 clk = ~clk;

  keyguard_ctrl #(.TIMEOUT_RST(TRST)) u_keyguard_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_cs(bus_cs), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .eng_ready(eng_ready), .eng_valid(eng_valid),
    .eng_init(eng_init), .eng_next(eng_next), .eng_zeroise(eng_zeroise),
    .key_loaded(key_loaded), .eng_key(eng_key));

  // Engine model: busy for four cycles after each init request.
  always @(negedge clk) begin
    if (eng_init) eng_busy = 4;
    else if (eng_busy > 0) eng_busy = eng_busy - 1;
    eng_ready = (eng_busy == 0);
  end

  // Monitor: pops the expected read data when a read is on the bus.
  always @(negedge clk) begin
    if (bus_cs && !bus_we && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (bus_rdata !== e) begin
        errors++;
        $display("FAIL %s: read 0x%02h actual=0x%08h expected=0x%08h", t, bus_addr, bus_rdata, e);
      end
    end
  end

  task automatic chk(input logic [255:0] act, input logic [255:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_cs = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_cs = 0; bus_we = 0;
  endtask

  task automatic rd_exp(input logic [7:0] a, input logic [31:0] e, input string tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    bus_cs = 1; bus_we = 0; bus_addr = a;
    @(posedge clk); #1;
    bus_cs = 0;
  endtask

  task automatic wait_loaded;
    for (int i = 0; i < 100; i++) begin
      if (key_loaded) break;
      step(1);
    end
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    step(4);
    rst_n = 1;
    step(1);
    // R1
    chk(eng_key, '0, "R1 key");
    chk({key_loaded, eng_init, eng_next, eng_zeroise}, 4'b0, "R1 flags");
    rd_exp(A_TMO, TRST, "R1 timeout default");
    // R5: ready=1 valid=1 loaded=0
    rd_exp(A_STATUS, 32'h3, "R5 status idle");

    // R2
    key_exp = '0;
    for (int i = 0; i < 8; i++) begin
      wr(A_KEY0 + 8'(i), 32'h1111_1111 * (i + 1));
      key_exp[(7 - i) * 32 +: 32] = 32'h1111_1111 * (i + 1);
    end
    chk(eng_key, key_exp, "R2 key order");
    rd_exp(A_KEY0 + 8'd2, 32'h0, "R2 key readback hidden");

    // R3
    wr(A_TMO, 32'hdeadbeef);
    rd_exp(A_TMO, 32'hdeadbeef, "R3 timeout readback");

    // R4 next strobe
    wr(A_CTRL, 32'h2);
    chk({eng_next, eng_init}, 2'b10, "R4 next pulse");
    step(1);
    chk(eng_next, 1'b0, "R4 next one cycle");

    // R6 expiry
    wr(A_TMO, 32'd8);
    wr(A_CTRL, 32'h1);
    chk(eng_init, 1'b1, "R4 init pulse");
    step(1);
    chk(eng_init, 1'b0, "R4 init one cycle");
    wait_loaded();
    chk(key_loaded, 1'b1, "R6 loaded after completion");
    step(8);
    chk(key_loaded, 1'b1, "R6 alive at timeout");
    step(1);
    chk(key_loaded, 1'b0, "R6 expired");
    chk(eng_key, '0, "R9 key cleared");
    chk({eng_zeroise, eng_init}, 2'b11, "R9 strobes");
    step(1);
    chk({eng_zeroise, eng_init}, 2'b00, "R9 strobes one cycle");
    step(10);
    chk(key_loaded, 1'b0, "R9 re-expansion not loaded");
    // R10
    rd_exp(A_STATUS, 32'h3, "R10 ping while idle");
    step(3);
    chk({key_loaded, eng_zeroise}, 2'b00, "R10 no effect");

    // R7 keep-alive
    wr(A_KEY0, 32'ha5a5_a5a5);
    wr(A_TMO, 32'd10);
    wr(A_CTRL, 32'h1);
    step(1);
    wait_loaded();
    for (int k = 0; k < 6; k++) begin
      step(5);
      rd_exp(A_STATUS, 32'h7, "R7 status while alive");
    end
    chk(key_loaded, 1'b1, "R7 kept alive");
    // R11: new timeout used from next ping
    wr(A_TMO, 32'd4);
    rd_exp(A_STATUS, 32'h7, "R11 ping reload");
    step(4);
    chk(key_loaded, 1'b1, "R11 alive after new timeout");
    step(1);
    chk(key_loaded, 1'b0, "R11 expired with new timeout");
    step(10);

    // R11: write does not change running count
    wr(A_TMO, 32'd12);
    wr(A_CTRL, 32'h1);
    step(1);
    wait_loaded();
    wr(A_TMO, 32'd3);
    step(11);
    chk(key_loaded, 1'b1, "R11 running count unchanged");
    step(1);
    chk(key_loaded, 1'b0, "R11 expiry at old timeout");
    step(10);

    // R8 forced wipe
    wr(A_TMO, 32'd1000);
    wr(A_KEY0 + 8'd7, 32'h1337_1337);
    wr(A_CTRL, 32'h1);
    step(1);
    wait_loaded();
    step(3);
    wr(A_CTRL, 32'h4);
    chk(key_loaded, 1'b0, "R8 wiped now");
    chk(eng_key, '0, "R8 key cleared");
    chk({eng_zeroise, eng_init}, 2'b11, "R8 strobes");
    step(12);
    chk(key_loaded, 1'b0, "R9 not reloaded after wipe");

    step(2);
    finish_run();
  end
endmodule